// File: doc/BRIEF.md
# Sparse pixel-row hit recorder

This block records binary hit flags from one row of pixels during an acquisition period. On each crossing strobe it captures the whole row at once. It then walks the row's sub-groups of six pixels in ascending order, one per clock. A record is written only for a sub-group that has at least one hit. Each record holds the crossing timestamp, the sub-group index and the six-bit hit pattern, so quiet parts of the row take no storage.

Records go into a small bank of write-once slots filled strictly in order. If a record needs a slot when every slot is taken, the record is lost and a sticky overflow flag is raised. After the acquisition period a read request streams out only the filled slots, with a flag on the final one. A clear input empties the bank for the next period. A test override makes every sub-group report all six pixels hit, which fills the bank with false hits.

The clock must run at least eight cycles per strobe period. The scan of one crossing ends seven cycles after its strobe, before the next strobe can arrive.

Top module: `row_hit_recorder`

## Requirements
- R1: After reset the overflow flag is low and no record is presented. A read request made before any crossing leaves `rd_valid` low.
- R2: `hits` and `override` are sampled only in the cycle where `strobe` is high. Changes to them between strobes have no effect on what is stored.
- R3: Sub-group g covers pixels 6g to 6g+5. Bit i of its pattern is pixel 6g+i. Within one crossing, records are stored in ascending g from 0 to 6, and the group field carries g.
- R4: A sub-group whose six sampled bits are all zero produces no record.
- R5: The timestamp is a 13-bit count that starts at 0 after reset. It advances by one on every strobe, including strobes with no hits, and wraps from 8191 to 0. Each record carries the count value of the crossing it came from.
- R6: The bank has 19 slots. Each slot is written at most once per period, and the write pointer only moves forward until a clear. Records are read out in the order they were stored.
- R7: When a record needs a slot and all 19 are filled, the record is dropped and `overflow` goes high. It stays high until a clear. Filling exactly 19 slots leaves `overflow` low.
- R8: A `read_start` pulse begins readout at the oldest record. `rd_valid` is high while a stored record is presented, and each cycle with `read_en` high advances to the next record. `rd_last` is high with the final stored record, and after it is consumed `rd_valid` goes low. Empty slots are never presented.
- R9: When `override` is high at a strobe, all seven sub-groups are stored with pattern 6'b111111.
- R10: A `clear` pulse empties the bank, resets the write pointer, lowers `overflow` and ends any readout. The timestamp count is not reset by it.
- R11: All records from a crossing are stored, and readable, by eight cycles after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, at least 8 cycles per strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle crossing strobe; samples the row |
| hits | input | 42 | Pixel hit flags, pixel p on bit p |
| override | input | 1 | Test mode: force every sub-group fully hit |
| clear | input | 1 | Empty the bank and drop overflow |
| read_start | input | 1 | Begin readout at the oldest record |
| read_en | input | 1 | Consume the presented record |
| rd_valid | output | 1 | A stored record is presented |
| rd_ts | output | 13 | Timestamp of the presented record |
| rd_grp | output | 3 | Sub-group index of the presented record |
| rd_pat | output | 6 | Hit pattern of the presented record |
| rd_last | output | 1 | Presented record is the final stored one |
| overflow | output | 1 | Sticky flag: a record was dropped for lack of space |

## Verification
A wrong write pointer shows up at the next readout. Records appear missing, duplicated or in the wrong order, or `rd_last` lands on the wrong record. A wrong scan index or snapshot shows up as a wrong group field or pattern within the eight cycles after a strobe, and the next readout exposes it. A fault in the timestamp count stays hidden until a record carries the bad value. For that reason the bench runs the count through a wrap. A fault in the fullness logic shows up at once on `overflow`, either as a flag raised at exactly 19 records or as a flag that falls without a clear.

// File: rtl/row_hit_recorder.sv
module row_hit_recorder #(
  parameter int NPIX  = 42,
  parameter int GRP   = 6,
  parameter int DEPTH = 19,
  parameter int TSW   = 13,
  localparam int NGRP = NPIX / GRP,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [NPIX-1:0] hits,
  input  logic            override,
  input  logic            clear,
  input  logic            read_start,
  input  logic            read_en,
  output logic            rd_valid,
  output logic [TSW-1:0]  rd_ts,
  output logic [GW-1:0]   rd_grp,
  output logic [GRP-1:0]  rd_pat,
  output logic            rd_last,
  output logic            overflow
);

  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [GW-1:0] LAST_GRP = GW'(NGRP - 1);

  logic [NPIX-1:0]  snap;
  logic [TSW-1:0]   snap_ts;
  logic [TSW-1:0]   ts_cnt;
  logic             scanning;
  logic [GW-1:0]    scan_idx;

  logic [PW-1:0]    wr_ptr;
  logic [DEPTH-1:0] valid;
  logic [TSW-1:0]   slot_ts  [DEPTH];
  logic [GW-1:0]    slot_grp [DEPTH];
  logic [GRP-1:0]   slot_pat [DEPTH];

  logic             reading;
  logic [PW-1:0]    rd_ptr;

  logic [GRP-1:0]   cur_pat;
  logic             need;
  logic             full;
  logic             wr_fire;

  assign cur_pat = snap[int'(scan_idx)*GRP +: GRP];
  assign need    = scanning && (|cur_pat);
  assign full    = (wr_ptr == FULL_CNT);
  assign wr_fire = need && !full && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap     <= '0;
      snap_ts  <= '0;
      ts_cnt   <= '0;
      scanning <= 1'b0;
      scan_idx <= '0;
    end else if (strobe) begin
      snap     <= override ? '1 : hits;
      snap_ts  <= ts_cnt;
      ts_cnt   <= ts_cnt + 1'b1;
      scanning <= 1'b1;
      scan_idx <= '0;
    end else if (scanning) begin
      if (scan_idx == LAST_GRP) scanning <= 1'b0;
      scan_idx <= scan_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      valid    <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      wr_ptr   <= '0;
      valid    <= '0;
      overflow <= 1'b0;
    end else if (need) begin
      if (full) begin
        overflow <= 1'b1;
      end else begin
        valid[wr_ptr] <= 1'b1;
        wr_ptr        <= wr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      slot_ts[wr_ptr]  <= snap_ts;
      slot_grp[wr_ptr] <= scan_idx;
      slot_pat[wr_ptr] <= cur_pat;
    end
  end

  assign rd_valid = reading && (rd_ptr < FULL_CNT) && valid[rd_ptr];
  assign rd_last  = rd_valid && ((rd_ptr + PW'(1)) == wr_ptr);
  assign rd_ts    = rd_valid ? slot_ts[rd_ptr]  : '0;
  assign rd_grp   = rd_valid ? slot_grp[rd_ptr] : '0;
  assign rd_pat   = rd_valid ? slot_pat[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      reading <= 1'b0;
      rd_ptr  <= '0;
    end else if (read_start) begin
      reading <= 1'b1;
      rd_ptr  <= '0;
    end else if (rd_valid && read_en) begin
      rd_ptr <= rd_ptr + 1'b1;
      if (rd_last) reading <= 1'b0;
    end
  end

endmodule

module row_hit_recorder_chk #(
  parameter int DEPTH = 19,
  parameter int PW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             overflow,
  input logic             rd_valid,
  input logic             rd_last,
  input logic             wr_fire,
  input logic [PW-1:0]    wr_ptr,
  input logic [DEPTH-1:0] valid
);

  assert_write_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !valid[wr_ptr]);

  assert_ptr_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (wr_ptr >= $past(wr_ptr)));

  assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PW'(DEPTH));

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  assert_overflow_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (wr_ptr == PW'(DEPTH)));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (wr_ptr == '0 && !overflow && !rd_valid));

  assert_last_is_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

endmodule

bind row_hit_recorder row_hit_recorder_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .overflow(overflow),
  .rd_valid(rd_valid), .rd_last(rd_last), .wr_fire(wr_fire),
  .wr_ptr(wr_ptr), .valid(valid)
);

// File: tb/sim_row_hit_recorder.sv
module sim_row_hit_recorder;
  localparam int NPIX = 42, GRP = 6, NGRP = 7, DEPTH = 19, TSW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, override = 1'b0, clear = 1'b0;
  logic read_start = 1'b0, read_en = 1'b0;
  logic [NPIX-1:0] hits = '0;
  logic rd_valid, rd_last, overflow;
  logic [TSW-1:0] rd_ts;
  logic [2:0] rd_grp;
  logic [GRP-1:0] rd_pat;

  int checks = 0, errors = 0;
  bit done = 0;

  int e_n = 0;
  bit e_ovf = 0;
  int e_ts = 0;
  int q_ts [DEPTH];
  int q_grp [DEPTH];
  int q_pat [DEPTH];

  always #10 clk = ~clk;

  row_hit_recorder u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .hits(hits), .override(override),
    .clear(clear), .read_start(read_start), .read_en(read_en),
    .rd_valid(rd_valid), .rd_ts(rd_ts), .rd_grp(rd_grp), .rd_pat(rd_pat),
    .rd_last(rd_last), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NPIX-1:0] rand_hits(input int density);
    logic [NPIX-1:0] h = '0;
    for (int p = 0; p < NPIX; p++) h[p] = (($urandom % density) == 0);
    return h;
  endfunction

  function automatic int grp_pat(input logic [NPIX-1:0] h, input int g);
    return int'(h[g*GRP +: GRP]);
  endfunction

  task automatic model_crossing(input logic [NPIX-1:0] h, input bit ov);
    logic [NPIX-1:0] eff = ov ? '1 : h;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_pat(eff, g) != 0) begin
        if (e_n < DEPTH) begin
          q_ts[e_n] = e_ts; q_grp[e_n] = g; q_pat[e_n] = grp_pat(eff, g);
          e_n++;
        end else e_ovf = 1;
      end
    end
    e_ts = (e_ts + 1) % (1 << TSW);
  endtask

  task automatic crossing(input logic [NPIX-1:0] h, input bit ov);
    @(negedge clk);
    hits = h; override = ov; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; override = ~ov;
    hits = NPIX'({$urandom(), $urandom()});
    model_crossing(h, ov);
    repeat (7) @(negedge clk);
    override = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    e_n = 0; e_ovf = 0;
  endtask

  task automatic readout();
    @(negedge clk); read_start = 1'b1;
    @(negedge clk); read_start = 1'b0;
    for (int i = 0; i < e_n; i++) begin
      chk(rd_valid == 1'b1, "R8 rd_valid", int'(rd_valid), 1);
      chk(int'(rd_ts) == q_ts[i], "R5 timestamp", int'(rd_ts), q_ts[i]);
      chk(int'(rd_grp) == q_grp[i], "R3 group", int'(rd_grp), q_grp[i]);
      chk(int'(rd_pat) == q_pat[i], "R3 pattern", int'(rd_pat), q_pat[i]);
      chk(rd_last == (i == e_n - 1), "R8 rd_last", int'(rd_last), int'(i == e_n - 1));
      read_en = 1'b1;
      @(negedge clk); read_en = 1'b0;
    end
    chk(rd_valid == 1'b0, "R8 end of stored records", int'(rd_valid), 0);
    chk(overflow == e_ovf, "R7 overflow", int'(overflow), int'(e_ovf));
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    readout();

    // R3 R4 R11: single pixel in group 0 and group 6 edges
    crossing(42'h1 | (42'h1 << 41), 1'b0);
    readout();
    // R4: empty crossing adds nothing but advances time (R5)
    crossing('0, 1'b0);
    crossing(42'h3F << 12, 1'b0);
    readout();

    // R2: hits wiggle with no strobe
    do_clear();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); hits = NPIX'({$urandom(), $urandom()}); override = k[0];
    end
    override = 1'b0;
    readout();

    // R9: override fills all groups
    crossing('0, 1'b1);
    readout();
    // R6 R7: exactly 19 then one more
    crossing('0, 1'b1);
    crossing(42'h1F_FFFF_FFFF & {42{1'b1}} & ~(42'h3F << 30) & ~(42'h3F << 36), 1'b0);
    chk(e_n == DEPTH, "R6 bench fill to capacity", e_n, DEPTH);
    readout();
    crossing(42'h1 << 20, 1'b0);
    readout();
    crossing('0, 1'b0);
    chk(overflow == 1'b1, "R7 sticky overflow", int'(overflow), 1);
    // R10: clear, timestamp continues
    do_clear();
    chk(overflow == 1'b0, "R10 overflow cleared", int'(overflow), 0);
    crossing(42'h2 << 6, 1'b0);
    readout();

    // R10: clear during readout ends it
    @(negedge clk); read_start = 1'b1;
    @(negedge clk); read_start = 1'b0;
    do_clear();
    chk(rd_valid == 1'b0, "R10 clear ends readout", int'(rd_valid), 0);

    // constrained random periods
    for (int per = 0; per < 30; per++) begin
      do_clear();
      for (int c = 0; c < 1 + int'($urandom % 6); c++)
        crossing(rand_hits(2 + int'($urandom % 20)), ($urandom % 10) == 0);
      readout();
      readout();
    end

    // R5 wrap
    do_clear();
    while (e_ts != (1 << TSW) - 1) crossing('0, 1'b0);
    crossing(42'h1 << 40, 1'b0);
    crossing(42'h1 << 3, 1'b0);
    chk(q_ts[1] == 0, "R5 bench wrap", q_ts[1], 0);
    readout();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule